// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block decodes the bus writes sent to a NOR flash array and turns them into operating modes. Each write arrives as a one-cycle strobe with an address and a data word. The block follows the multi-write unlock and command sequences, and it decides whether a read returns array contents, identification codes or operation status. Once a program or sector-erase sequence is complete, it launches an embedded algorithm engine. It then tracks that engine through a start pulse, a done pulse, a failure pulse and a hold line.

A sequence always begins with two unlock writes. The first puts 0xAA at unlock address 0x555 and the second puts 0x55 at 0x2AA, and the unlock decoder compares only the low `UNLK_W` address bits. A command byte written at 0x555 then selects the action: 0x90 for identification, 0xA0 for program, or 0x80 for erase setup. An erase needs a second unlock pair and then a 0x30 write at any address inside the target sector. A running erase can be suspended with 0xB0 and resumed with 0x30. While it is suspended, reads of the suspended sector report status and every other sector stays readable. A program or an identification session can also be run during the suspension.

The read side presents only the sector bits of the read address (`rd_sector`, the top `log2(N_SECT)` address bits). The block reports the chosen read source as a code, and the datapath uses that code to steer its output mux.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, `rd_src` is 0 (array), and `busy`, `eng_start` and `eng_hold` are all low. No command is needed before array reads.
- R2: Two unlock writes followed by 0x90 at 0x555 enter identification mode, in which `rd_src` is 1 for every `rd_sector`. Writes other than 0xF0 leave the mode unchanged. A 0xF0 write at any address leaves the mode.
- R3: A write that does not match the next expected step of a sequence returns the block to its base read mode (array, or erase-suspended if a suspension is pending). After that, an incomplete tail of the sequence has no effect.
- R4: 0xF0 written at any address between the cycles of an erase sequence aborts the sequence before any engine start. The remaining erase writes then cause no start.
- R5: After the unlock pair and 0xA0 at 0x555, the next write starts a program. On the edge that takes this write, `eng_start` rises for exactly one cycle with `eng_op`=0 and `eng_addr`/`eng_data` equal to the written values, and `busy` rises. `busy` stays high and `rd_src` reads 2 (status) until the edge that samples `eng_done`. After that edge the mode returns to base read.
- R6: While an engine operation runs, a 0xF0 write is ignored and `busy` stays high.
- R7: The unlock pair, 0x80 at 0x555, a second unlock pair, then 0x30 at address A starts an erase. `eng_start` pulses with `eng_op`=1 and `eng_addr`=A. After `eng_done` the block returns to array reads.
- R8: An `eng_fail` pulse during a running operation enters a fault mode: `busy` drops and `rd_src` is 2. Writes other than 0xF0 are ignored, and a 0xF0 write returns the block to base read.
- R9: 0xB0 during a running erase suspends it: `busy` drops and `eng_hold` rises. `rd_src` is 2 for the erased sector and 0 for all other sectors. A 0x30 write resumes the erase with `busy` high, `eng_hold` low and no new `eng_start`.
- R10: During a suspension, a program sequence starts a program with `eng_hold` still high. When the program completes, the block returns to the suspended read rule.
- R11: During a suspension, identification mode can be entered. Its 0xF0 exit returns to the suspended read rule, not to plain array reads, and an erase-setup command is treated as a wrong cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data / command byte |
| rd_sector | input | log2(N_SECT) | Sector bits of the current read address |
| rd_src | output | 2 | Read source: 0 array, 1 identification, 2 status |
| busy | output | 1 | Embedded operation in progress |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_op | output | 1 | Operation for the engine: 0 program, 1 erase |
| eng_addr | output | ADDR_W | Target address for the engine |
| eng_data | output | DATA_W | Program data for the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_fail | input | 1 | Engine failure pulse |
| eng_hold | output | 1 | Erase is suspended; engine must pause the erase |

## Verification
The embedded assertions take it for granted that the engine raises `eng_done` or `eng_fail` only while an operation it was given is running. They also assume that the engine never raises both in the same cycle, and that every write lasts exactly one cycle. The bench engine model is a pair of countdown counters that report only for an operation they hold and that freeze the erase count while `eng_hold` is high. Failures are injected only while a program is counting and well before its done pulse is due. The write task always drops `wr_en` after one cycle.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;

   typedef enum logic [3:0] {
      ST_READ,
      ST_UL1,
      ST_UL2,
      ST_PGM_DATA,
      ST_ERS_SETUP,
      ST_ERS_UL1,
      ST_ERS_UL2,
      ST_PGM_RUN,
      ST_ERS_RUN,
      ST_SUSP,
      ST_IDENT,
      ST_FAULT
   } fcs_state_e;

   typedef enum logic [1:0] {
      SRC_ARRAY  = 2'd0,
      SRC_IDENT  = 2'd1,
      SRC_STATUS = 2'd2
   } fcs_src_e;

   typedef struct packed {
      logic ul1;
      logic ul2;
      logic at_cmd_addr;
      logic c_reset;
      logic c_ident;
      logic c_prog;
      logic c_erase_setup;
      logic c_erase_go;
      logic c_suspend;
      logic c_resume;
   } fcs_wr_class_t;

endpackage

// File: rtl/fcs_decode.sv
`timescale 1ns/1ps
module fcs_decode
   import fcs_pkg::*;
#(
   parameter int unsigned UNLK_W          = 11,
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned UL1_ADDR        = 'h555,
   parameter int unsigned UL1_DATA        = 'hAA,
   parameter int unsigned UL2_ADDR        = 'h2AA,
   parameter int unsigned UL2_DATA        = 'h55,
   parameter int unsigned CMD_RESET       = 'hF0,
   parameter int unsigned CMD_IDENT       = 'h90,
   parameter int unsigned CMD_PROG        = 'hA0,
   parameter int unsigned CMD_ERASE_SETUP = 'h80,
   parameter int unsigned CMD_ERASE_GO    = 'h30,
   parameter int unsigned CMD_SUSPEND     = 'hB0,
   parameter int unsigned CMD_RESUME      = 'h30
) (
   input  logic [UNLK_W-1:0] key,
   input  logic              hi_ok,
   input  logic [DATA_W-1:0] dat,
   output fcs_wr_class_t     cls
);

   localparam logic [UNLK_W-1:0] K1 = UNLK_W'(UL1_ADDR);
   localparam logic [UNLK_W-1:0] K2 = UNLK_W'(UL2_ADDR);

   logic key1, key2;

   assign key1 = hi_ok && (key == K1);
   assign key2 = hi_ok && (key == K2);

   always_comb begin
      cls               = '0;
      cls.ul1           = key1 && (dat == DATA_W'(UL1_DATA));
      cls.ul2           = key2 && (dat == DATA_W'(UL2_DATA));
      cls.at_cmd_addr   = key1;
      cls.c_reset       = (dat == DATA_W'(CMD_RESET));
      cls.c_ident       = (dat == DATA_W'(CMD_IDENT));
      cls.c_prog        = (dat == DATA_W'(CMD_PROG));
      cls.c_erase_setup = (dat == DATA_W'(CMD_ERASE_SETUP));
      cls.c_erase_go    = (dat == DATA_W'(CMD_ERASE_GO));
      cls.c_suspend     = (dat == DATA_W'(CMD_SUSPEND));
      cls.c_resume      = (dat == DATA_W'(CMD_RESUME));
   end

endmodule

// File: rtl/fcs_ctrl.sv
`timescale 1ns/1ps
module fcs_ctrl
   import fcs_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned N_SECT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  fcs_wr_class_t     cls,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              eng_done,
   input  logic              eng_fail,
   output fcs_state_e        state,
   output logic              susp,
   output logic [N_SECT-1:0] susp_mask,
   output logic              eng_start,
   output logic              eng_op,
   output logic [ADDR_W-1:0] eng_addr,
   output logic [DATA_W-1:0] eng_data
);

   localparam int unsigned SECT_W = $clog2(N_SECT);

   fcs_state_e        nxt, base;
   logic              susp_nxt, start_nxt;
   logic [N_SECT-1:0] mask_nxt;
   logic [SECT_W-1:0] wr_sect;

   assign wr_sect = wr_addr[ADDR_W-1 -: SECT_W];
   assign base    = susp ? ST_SUSP : ST_READ;

   always_comb begin
      nxt       = state;
      susp_nxt  = susp;
      start_nxt = 1'b0;
      mask_nxt  = susp_mask;
      unique case (state)
         ST_READ: begin
            if (wr_en && cls.ul1) nxt = ST_UL1;
         end
         ST_SUSP: begin
            if (wr_en) begin
               if (cls.ul1) nxt = ST_UL1;
               else if (cls.c_resume) begin
                  nxt      = ST_ERS_RUN;
                  susp_nxt = 1'b0;
               end
            end
         end
         ST_UL1: begin
            if (wr_en) nxt = cls.ul2 ? ST_UL2 : base;
         end
         ST_UL2: begin
            if (wr_en) begin
               if (cls.at_cmd_addr && cls.c_ident)                  nxt = ST_IDENT;
               else if (cls.at_cmd_addr && cls.c_prog)              nxt = ST_PGM_DATA;
               else if (cls.at_cmd_addr && cls.c_erase_setup && !susp) nxt = ST_ERS_SETUP;
               else                                                  nxt = base;
            end
         end
         ST_PGM_DATA: begin
            if (wr_en) begin
               nxt       = ST_PGM_RUN;
               start_nxt = 1'b1;
            end
         end
         ST_ERS_SETUP: begin
            if (wr_en) nxt = cls.ul1 ? ST_ERS_UL1 : base;
         end
         ST_ERS_UL1: begin
            if (wr_en) nxt = cls.ul2 ? ST_ERS_UL2 : base;
         end
         ST_ERS_UL2: begin
            if (wr_en) begin
               if (cls.c_erase_go) begin
                  nxt               = ST_ERS_RUN;
                  start_nxt         = 1'b1;
                  mask_nxt          = '0;
                  mask_nxt[wr_sect] = 1'b1;
               end else begin
                  nxt = base;
               end
            end
         end
         ST_PGM_RUN: begin
            if (eng_fail)      nxt = ST_FAULT;
            else if (eng_done) nxt = base;
         end
         ST_ERS_RUN: begin
            if (eng_fail)      nxt = ST_FAULT;
            else if (eng_done) nxt = ST_READ;
            else if (wr_en && cls.c_suspend) begin
               nxt      = ST_SUSP;
               susp_nxt = 1'b1;
            end
         end
         ST_IDENT, ST_FAULT: begin
            if (wr_en && cls.c_reset) nxt = base;
         end
         default: nxt = ST_READ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_READ;
         susp      <= 1'b0;
         susp_mask <= '0;
         eng_start <= 1'b0;
         eng_op    <= 1'b0;
         eng_addr  <= '0;
         eng_data  <= '0;
      end else begin
         state     <= nxt;
         susp      <= susp_nxt;
         susp_mask <= mask_nxt;
         eng_start <= start_nxt;
         if (start_nxt) begin
            eng_op   <= (state == ST_ERS_UL2);
            eng_addr <= wr_addr;
            eng_data <= wr_data;
         end
      end
   end

   // R2: identification mode is left only through the reset command
   p_ident_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDENT && !(wr_en && cls.c_reset)) |=> state == ST_IDENT);

   // R3: a wrong second unlock cycle in plain mode returns to array reads
   p_wrong_fallback_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_UL1 && wr_en && !cls.ul2 && !susp) |=> state == ST_READ);

   // R5: start is a single-cycle pulse
   p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

   // R5: program completion outside a suspension lands in array reads
   p_done_to_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PGM_RUN && eng_done && !eng_fail && !susp) |=> state == ST_READ);

   // R6: reset command is ignored while a program runs
   p_run_ignores_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PGM_RUN && wr_en && cls.c_reset && !eng_done && !eng_fail)
      |=> state == ST_PGM_RUN);

   // R8: fault mode holds until a reset command
   p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FAULT && !(wr_en && cls.c_reset)) |=> state == ST_FAULT);

   // R9: a suspended erase is never counted as running
   p_susp_no_erase_r9: assert property (@(posedge clk) disable iff (!rst_n)
      susp |-> state != ST_ERS_RUN);

endmodule

// File: rtl/fcs_rdsel.sv
`timescale 1ns/1ps
module fcs_rdsel
   import fcs_pkg::*;
#(
   parameter int unsigned N_SECT = 8
) (
   input  fcs_state_e                 state,
   input  logic                       susp,
   input  logic [N_SECT-1:0]          susp_mask,
   input  logic [$clog2(N_SECT)-1:0]  rd_sector,
   output fcs_src_e                   src
);

   localparam int unsigned SECT_W = $clog2(N_SECT);

   logic [N_SECT-1:0] hit;
   logic              in_susp_sect;

   for (genvar i = 0; i < N_SECT; i++) begin : g_sect
      assign hit[i] = susp_mask[i] && (rd_sector == SECT_W'(i));
   end

   assign in_susp_sect = |hit;

   always_comb begin
      if (state == ST_IDENT)
         src = SRC_IDENT;
      else if (state == ST_PGM_RUN || state == ST_ERS_RUN || state == ST_FAULT)
         src = SRC_STATUS;
      else if (susp && in_susp_sect)
         src = SRC_STATUS;
      else
         src = SRC_ARRAY;
   end

   // R9: at most one sector is marked as suspended
   always_comb begin
      p_one_sector_r9: assert ($onehot0(susp_mask));
   end

endmodule

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
   import fcs_pkg::*;
#(
   parameter int unsigned ADDR_W          = 12,
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned UNLK_W          = 11,
   parameter int unsigned N_SECT          = 8,
   parameter bit          STRICT_UL       = 1'b0,
   parameter int unsigned UL1_ADDR        = 'h555,
   parameter int unsigned UL1_DATA        = 'hAA,
   parameter int unsigned UL2_ADDR        = 'h2AA,
   parameter int unsigned UL2_DATA        = 'h55,
   parameter int unsigned CMD_RESET       = 'hF0,
   parameter int unsigned CMD_IDENT       = 'h90,
   parameter int unsigned CMD_PROG        = 'hA0,
   parameter int unsigned CMD_ERASE_SETUP = 'h80,
   parameter int unsigned CMD_ERASE_GO    = 'h30,
   parameter int unsigned CMD_SUSPEND     = 'hB0,
   parameter int unsigned CMD_RESUME      = 'h30
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [$clog2(N_SECT)-1:0]  rd_sector,
   output logic [1:0]                 rd_src,
   output logic                       busy,
   output logic                       eng_start,
   output logic                       eng_op,
   output logic [ADDR_W-1:0]          eng_addr,
   output logic [DATA_W-1:0]          eng_data,
   input  logic                       eng_done,
   input  logic                       eng_fail,
   output logic                       eng_hold
);

   localparam int unsigned SECT_W = $clog2(N_SECT);

   if (N_SECT < 2 || (1 << SECT_W) != N_SECT) begin : g_bad_sect
      $error("N_SECT must be a power of two of at least 2");
   end
   if (UNLK_W > ADDR_W || UNLK_W < 2) begin : g_bad_unlk
      $error("UNLK_W must lie in 2..ADDR_W");
   end
   if (SECT_W >= ADDR_W) begin : g_bad_addr
      $error("ADDR_W too small for the sector count");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must hold a command byte");
   end

   fcs_wr_class_t     cls;
   fcs_state_e        state;
   fcs_src_e          src;
   logic              susp;
   logic [N_SECT-1:0] susp_mask;
   logic              hi_ok;

   if (STRICT_UL && UNLK_W < ADDR_W) begin : g_strict
      assign hi_ok = ~|wr_addr[ADDR_W-1:UNLK_W];
   end else begin : g_loose
      assign hi_ok = 1'b1;
   end

   fcs_decode #(
      .UNLK_W(UNLK_W), .DATA_W(DATA_W),
      .UL1_ADDR(UL1_ADDR), .UL1_DATA(UL1_DATA),
      .UL2_ADDR(UL2_ADDR), .UL2_DATA(UL2_DATA),
      .CMD_RESET(CMD_RESET), .CMD_IDENT(CMD_IDENT), .CMD_PROG(CMD_PROG),
      .CMD_ERASE_SETUP(CMD_ERASE_SETUP), .CMD_ERASE_GO(CMD_ERASE_GO),
      .CMD_SUSPEND(CMD_SUSPEND), .CMD_RESUME(CMD_RESUME)
   ) u_decode (
      .key   (wr_addr[UNLK_W-1:0]),
      .hi_ok (hi_ok),
      .dat   (wr_data),
      .cls   (cls)
   );

   fcs_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SECT(N_SECT)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .cls       (cls),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .eng_done  (eng_done),
      .eng_fail  (eng_fail),
      .state     (state),
      .susp      (susp),
      .susp_mask (susp_mask),
      .eng_start (eng_start),
      .eng_op    (eng_op),
      .eng_addr  (eng_addr),
      .eng_data  (eng_data)
   );

   fcs_rdsel #(.N_SECT(N_SECT)) u_rdsel (
      .state     (state),
      .susp      (susp),
      .susp_mask (susp_mask),
      .rd_sector (rd_sector),
      .src       (src)
   );

   assign rd_src   = src;
   assign busy     = (state == ST_PGM_RUN) || (state == ST_ERS_RUN);
   assign eng_hold = susp;

   // R5: while busy, reads always report status
   p_busy_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> rd_src == 2'd2);

   // R9: a start pulse never coincides with an idle machine
   p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> busy);

endmodule

// File: tb/flash_cmd_fsm_tb.sv
`timescale 1ns/1ps
module flash_cmd_fsm_tb;

   localparam int PLEN = 8;
   localparam int ELEN = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [2:0]  rd_sector = '0;
   logic [1:0]  rd_src;
   logic        busy, eng_start, eng_op, eng_hold;
   logic [11:0] eng_addr;
   logic [7:0]  eng_data;
   logic        eng_done;
   logic        eng_fail = 1'b0;

   int nchk = 0;
   int nerr = 0;

   always #4 clk = ~clk;

   flash_cmd_fsm u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_sector(rd_sector), .rd_src(rd_src), .busy(busy), .eng_start(eng_start),
      .eng_op(eng_op), .eng_addr(eng_addr), .eng_data(eng_data),
      .eng_done(eng_done), .eng_fail(eng_fail), .eng_hold(eng_hold)
   );

   // engine model: two countdown counters, erase frozen while held
   int  p_cnt, e_cnt;
   logic p_act, e_act;
   always @(posedge clk) begin
      if (!rst_n || eng_fail) begin
         p_act <= 1'b0; e_act <= 1'b0; eng_done <= 1'b0;
         p_cnt <= 0;    e_cnt <= 0;
      end else begin
         eng_done <= 1'b0;
         if (eng_start && !eng_op) begin p_act <= 1'b1; p_cnt <= PLEN; end
         else if (eng_start && eng_op) begin e_act <= 1'b1; e_cnt <= ELEN; end
         else begin
            if (p_act) begin
               if (p_cnt == 0) begin eng_done <= 1'b1; p_act <= 1'b0; end
               else p_cnt <= p_cnt - 1;
            end else if (e_act && !eng_hold) begin
               if (e_cnt == 0) begin eng_done <= 1'b1; e_act <= 1'b0; end
               else e_cnt <= e_cnt - 1;
            end
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic unlock();
      wr(12'h555, 8'hAA);
      wr(12'h2AA, 8'h55);
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!eng_done);
      @(negedge clk);
   endtask

   task automatic sweep_susp(input string tag, input int esect);
      for (int s = 0; s < 8; s++) begin
         rd_sector = 3'(s);
         #1;
         chk(tag, int'(rd_src), (s == esect) ? 2 : 0);
      end
      rd_sector = '0;
   endtask

   initial begin
      #(8 * 150000);
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rd_src", int'(rd_src), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 eng_start", int'(eng_start), 0);
      chk("R1 eng_hold", int'(eng_hold), 0);

      // sweep of every command byte after the unlock pair
      for (int c = 0; c < 256; c++) begin
         unlock();
         wr(12'h555, 8'(c));
         if (c == 'h90) begin
            chk("R2 ident entry", int'(rd_src), 1);
            wr(12'h123, 8'h00);
            chk("R2 ident ignores write", int'(rd_src), 1);
            wr(12'h7FF, 8'hF0);
            chk("R2 ident exit", int'(rd_src), 0);
         end else if (c == 'hA0) begin
            wr(12'h9AB, 8'h5C);
            chk("R5 start", int'(eng_start), 1);
            chk("R5 op", int'(eng_op), 0);
            chk("R5 addr", int'(eng_addr), 'h9AB);
            chk("R5 data", int'(eng_data), 'h5C);
            chk("R5 busy", int'(busy), 1);
            chk("R5 status", int'(rd_src), 2);
            @(negedge clk);
            chk("R5 single pulse", int'(eng_start), 0);
            wait_done();
            chk("R5 done busy", int'(busy), 0);
            chk("R5 done array", int'(rd_src), 0);
         end else if (c == 'h80) begin
            wr(12'h100, 8'hF0);
            unlock();
            wr(12'hA40, 8'h30);
            chk("R4 abort no start", int'(eng_start), 0);
            chk("R4 abort not busy", int'(busy), 0);
         end else begin
            wr(12'h555, 8'h90);
            chk("R3 wrong cmd falls back", int'(rd_src), 0);
            chk("R3 no start", int'(eng_start) | int'(busy), 0);
         end
      end

      // sweep of the second unlock data value
      for (int d = 0; d < 256; d++) begin
         wr(12'h555, 8'hAA);
         wr(12'h2AA, 8'(d));
         wr(12'h555, 8'h90);
         chk("R3 second unlock sweep", int'(rd_src), (d == 'h55) ? 1 : 0);
         if (d == 'h55) wr(12'h000, 8'hF0);
      end
      // wrong second unlock address
      wr(12'h555, 8'hAA);
      wr(12'h2AB, 8'h55);
      wr(12'h555, 8'h90);
      chk("R3 wrong unlock address", int'(rd_src), 0);

      // R6 reset ignored while program runs
      unlock();
      wr(12'h555, 8'hA0);
      wr(12'h040, 8'h3C);
      wr(12'h000, 8'hF0);
      chk("R6 busy after reset cmd", int'(busy), 1);
      chk("R6 status", int'(rd_src), 2);
      wait_done();
      chk("R6 done array", int'(rd_src), 0);

      // R8 fault
      unlock();
      wr(12'h555, 8'hA0);
      wr(12'h050, 8'h11);
      @(negedge clk); eng_fail = 1'b1;
      @(negedge clk); eng_fail = 1'b0;
      chk("R8 fault busy", int'(busy), 0);
      chk("R8 fault status", int'(rd_src), 2);
      wr(12'h555, 8'hAA);
      chk("R8 fault ignores write", int'(rd_src), 2);
      wr(12'h3FF, 8'hF0);
      chk("R8 fault exit", int'(rd_src), 0);

      // R7 erase of sector 5, then R9 suspend
      unlock();
      wr(12'h555, 8'h80);
      unlock();
      wr(12'hA40, 8'h30);
      chk("R7 start", int'(eng_start), 1);
      chk("R7 op", int'(eng_op), 1);
      chk("R7 addr", int'(eng_addr), 'hA40);
      chk("R7 busy", int'(busy), 1);
      wr(12'h000, 8'hB0);
      chk("R9 suspend busy", int'(busy), 0);
      chk("R9 suspend hold", int'(eng_hold), 1);
      sweep_susp("R9 suspended read", 5);
      repeat (60) @(negedge clk);
      chk("R9 erase frozen", int'(busy), 0);

      // R10 program during suspension
      unlock();
      wr(12'h555, 8'hA0);
      wr(12'h200, 8'h77);
      chk("R10 start", int'(eng_start), 1);
      chk("R10 op", int'(eng_op), 0);
      chk("R10 busy", int'(busy), 1);
      chk("R10 hold", int'(eng_hold), 1);
      wait_done();
      chk("R10 back to suspend", int'(busy), 0);
      chk("R10 hold kept", int'(eng_hold), 1);
      sweep_susp("R10 read rule", 5);

      // R11 ident during suspension, erase setup rejected
      unlock();
      wr(12'h555, 8'h90);
      chk("R11 ident", int'(rd_src), 1);
      wr(12'h000, 8'h00);
      chk("R11 ident ignores write", int'(rd_src), 1);
      wr(12'h000, 8'hF0);
      chk("R11 hold after exit", int'(eng_hold), 1);
      sweep_susp("R11 read rule", 5);
      unlock();
      wr(12'h555, 8'h80);
      unlock();
      wr(12'hA40, 8'h30);
      chk("R11 erase setup rejected", int'(eng_start) | int'(busy), 0);
      chk("R11 still suspended", int'(eng_hold), 1);

      // R9 resume
      wr(12'h000, 8'h30);
      chk("R9 resume busy", int'(busy), 1);
      chk("R9 resume hold", int'(eng_hold), 0);
      chk("R9 resume no start", int'(eng_start), 0);
      wait_done();
      rd_sector = 3'd5;
      #1;
      chk("R7 erase done array", int'(rd_src), 0);
      chk("R7 erase done busy", int'(busy), 0);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule